// File: doc/BRIEF.md
# Idle-Synchronized Hub Port Enable Gate

This block sits between the per-port enable requests of a multi-port two-wire bus hub and the hub's repeater core. It turns the requested enables into applied enables, and commits a change only when the shared bus and the affected local port are both between transfers. A port whose applied enable is low is masked from the hub by the repeater: its inputs are ignored and its pull-down driver is held off. Port 0 has no enable and is always active.

Transfers are tracked by watching START and STOP conditions on the resolved SDA and SCL values of the shared bus and of each port. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A line pair counts as idle from a STOP that has been followed by a hold window of `HOLD_CYC` clocks, until the next START. A request made during a transfer stays pending, and the latest requested value is applied at the next idle point. After each commit, `busy` stays high for a set-up window of `SETUP_CYC` clocks, so that local masters can hold off a new START until the change has settled. All inputs pass through a synchronizer before use.

Top module: `hub_enable_gate`

## Requirements
- R1: After reset, every bit of `en_app` is 1 and `busy` is 0.
- R2: `en_app[0]` is always 1, whatever the value of `en_req[0]`.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a START on the shared bus, no bit of `en_app` changes until the shared bus is idle again.
- R4: A change to `en_app[i]` (i ≥ 1) also needs port i's own line pair to be idle. A transfer on port i does not hold back changes to the other ports.
- R5: After a STOP, the line pair becomes idle only `HOLD_CYC` clocks later. A pending change is not committed inside that window.
- R6: A request that differs from the applied value while blocked is kept pending. The value of `en_req` at the idle point is what gets applied, even after several changes.
- R7: `busy` is 1 while any `en_req[i]` (i ≥ 1) differs from `en_app[i]`, and for `SETUP_CYC` clocks after each commit. Otherwise it is 0.
- R8: When everything is idle, a changed request appears on `en_app` within 4 clocks. It does not appear in the clock after the change, because of the input synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | NPORT | Raw enable requests, one per port (bit 0 ignored) |
| bus_sda | input | 1 | Resolved SDA of the shared bus |
| bus_scl | input | 1 | Resolved SCL of the shared bus |
| port_sda | input | NPORT | Resolved SDA of each port |
| port_scl | input | NPORT | Resolved SCL of each port |
| en_app | output | NPORT | Applied enables, handed to the repeater |
| busy | output | 1 | Change pending or inside the set-up window |

## Verification
The assertions check on every cycle that port 0 stays enabled, that the applied vector changes only while the shared bus tracker reports idle, that a port changes only while its own tracker reports idle, that each changed bit takes the synchronized request value, and that `busy` is raised after each commit. The exact lengths of the hold and set-up windows, the way a pending request keeps only its latest value, and the independence of ports from a transfer on another port can only be shown by the bench. It does so by driving START and STOP sequences on chosen line pairs while the requests change.

// File: rtl/hub_enable_gate.sv
module hub_enable_gate #(
  parameter int NPORT     = 5,
  parameter int SYNC      = 2,
  parameter int HOLD_CYC  = 75,
  parameter int SETUP_CYC = 75
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] en_req,
  input  logic             bus_sda,
  input  logic             bus_scl,
  input  logic [NPORT-1:0] port_sda,
  input  logic [NPORT-1:0] port_scl,
  output logic [NPORT-1:0] en_app,
  output logic             busy
);
  localparam int NL = NPORT + 1;
  localparam int W  = NPORT + 2 * NL;
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int SW = $clog2(SETUP_CYC + 1);

  logic [W-1:0] sq [SYNC];
  logic [W-1:0] raw, syn;
  logic [NL-1:0] sda, scl, sda_q, scl_q, idle;
  logic [NPORT-1:0] req_s, go;
  logic [SW-1:0] scnt;

  assign raw = {en_req, port_scl, bus_scl, port_sda, bus_sda};
  assign syn = sq[SYNC-1];
  assign sda = syn[NL-1:0];
  assign scl = syn[2*NL-1:NL];
  assign req_s = syn[W-1:2*NL];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int s = 0; s < SYNC; s++) sq[s] <= {{NPORT{1'b1}}, {(2*NL){1'b1}}};
      sda_q <= '1;
      scl_q <= '1;
    end else begin
      sq[0] <= raw;
      for (int s = 1; s < SYNC; s++) sq[s] <= sq[s-1];
      sda_q <= sda;
      scl_q <= scl;
    end

  for (genvar g = 0; g < NL; g++) begin : g_trk
    logic start, stop, armed;
    logic [HW-1:0] cnt;
    assign start = sda_q[g] & ~sda[g] & scl_q[g] & scl[g];
    assign stop  = ~sda_q[g] & sda[g] & scl_q[g] & scl[g];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        idle[g] <= 1'b1;
        armed   <= 1'b0;
        cnt     <= '0;
      end else if (start) begin
        idle[g] <= 1'b0;
        armed   <= 1'b0;
      end else if (stop) begin
        idle[g] <= 1'b0;
        armed   <= 1'b1;
        cnt     <= '0;
      end else if (armed) begin
        if (cnt == HW'(HOLD_CYC - 1)) begin
          idle[g] <= 1'b1;
          armed   <= 1'b0;
        end else cnt <= cnt + 1'b1;
      end
  end

  assign go = (req_s ^ en_app) & idle[NL-1:1] & {NPORT{idle[0]}} & {{(NPORT-1){1'b1}}, 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_app <= '1;
      scnt   <= '0;
    end else begin
      en_app <= (en_app & ~go) | (req_s & go);
      if (|go) scnt <= SW'(SETUP_CYC);
      else if (scnt != '0) scnt <= scnt - 1'b1;
    end

  assign busy = (|((req_s ^ en_app) & {{(NPORT-1){1'b1}}, 1'b0})) | (scnt != '0);
endmodule

module hub_enable_gate_chk #(parameter int NPORT = 5) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] en_app,
  input logic [NPORT-1:0] req_s,
  input logic [NPORT:0]   idle,
  input logic             busy
);
  p_port0_on_r2: assert property (@(posedge clk) disable iff (!rst_n) en_app[0]);
  p_bus_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_app) |-> $past(idle[0]));
  p_port_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(en_app) ^ en_app) & ~$past(idle[NPORT:1])) == '0));
  p_latest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(en_app) ^ en_app) & (en_app ^ $past(req_s))) == '0));
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_app) |-> busy);
endmodule

bind hub_enable_gate hub_enable_gate_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_app(en_app), .req_s(req_s), .idle(idle), .busy(busy));

// File: tb/hub_enable_gate_tb_top.sv
module hub_enable_gate_tb_top;
  localparam int N = 5, HOLD = 75, SETUP = 75;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] en_req = '1, port_sda = '1, port_scl = '1;
  logic bus_sda = 1, bus_scl = 1;
  logic [N-1:0] en_app;
  logic busy;
  int checks = 0, errors = 0;
  logic [N-1:0] applied;

  always #2 clk = ~clk;

  hub_enable_gate #(.NPORT(N), .HOLD_CYC(HOLD), .SETUP_CYC(SETUP)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .bus_sda(bus_sda), .bus_scl(bus_scl),
    .port_sda(port_sda), .port_scl(port_scl), .en_app(en_app), .busy(busy));

  function automatic logic [N-1:0] expect_en(logic [N-1:0] prev, logic [N-1:0] req,
                                             logic [N-1:0] blocked);
    logic [N-1:0] r;
    r = (req & ~blocked) | (prev & blocked);
    r[0] = 1'b1;
    return r;
  endfunction

  task automatic chk(bit ok, string rq, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(int w, bit sd, bit sc);
    if (w == 0) begin bus_sda = sd; bus_scl = sc; end
    else begin port_sda[w-1] = sd; port_scl[w-1] = sc; end
  endtask

  task automatic do_start(int w);
    set_line(w, 0, 1); cyc(4); set_line(w, 0, 0); cyc(4);
  endtask

  task automatic do_stop(int w);
    set_line(w, 0, 1); cyc(4); set_line(w, 1, 1);
  endtask

  initial begin
    void'($urandom(32'd7));
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk(en_app == '1, "R1 reset enables", en_app, '1);
    chk(busy == 0, "R1 reset busy", {{(N-1){1'b0}}, busy}, '0);

    en_req = 5'b11110;
    cyc(6);
    chk(en_app == '1, "R2 port0 ignores request", en_app, '1);
    chk(busy == 0, "R2 no busy from port0", {{(N-1){1'b0}}, busy}, '0);

    en_req = 5'b11011;
    cyc(1);
    chk(en_app == '1, "R8 not in first clock", en_app, '1);
    cyc(3);
    chk(en_app == 5'b11011, "R8 applied within 4 clocks", en_app, 5'b11011);
    cyc(SETUP - 15);
    chk(busy == 1, "R7 busy inside setup window", {{(N-1){1'b0}}, busy}, 1);
    cyc(20);
    chk(busy == 0, "R7 busy clears after setup", {{(N-1){1'b0}}, busy}, 0);

    do_start(0);
    en_req = 5'b00001;
    cyc(10);
    chk(en_app == 5'b11011, "R3 held during shared transfer", en_app, 5'b11011);
    chk(busy == 1, "R7 busy while pending", {{(N-1){1'b0}}, busy}, 1);
    en_req = 5'b10101;
    cyc(10);
    en_req = 5'b01111;
    do_stop(0);
    cyc(HOLD / 2);
    chk(en_app == 5'b11011, "R5 held in hold window", en_app, 5'b11011);
    cyc(HOLD);
    chk(en_app == 5'b01111, "R6 latest value applied", en_app, 5'b01111);
    cyc(SETUP + 10);

    do_start(3);
    en_req = 5'b10001;
    cyc(10);
    chk(en_app == 5'b10101, "R4 other ports proceed, port2 held", en_app, 5'b10101);
    do_stop(3);
    cyc(HOLD + 10);
    chk(en_app == 5'b10001, "R4 port2 applied after its idle", en_app, 5'b10001);
    cyc(SETUP + 10);
    applied = en_app;

    for (int it = 0; it < 40; it++) begin
      logic [N-1:0] nr, blk;
      int w;
      nr = N'($urandom);
      w = $urandom_range(0, N);
      blk = (w == 0) ? '1 : (N'(1) << (w - 1));
      do_start(w);
      en_req = nr;
      cyc(12);
      chk(en_app == expect_en(applied, nr, blk), (w == 0) ? "R3 random held" : "R4 random per-port",
          en_app, expect_en(applied, nr, blk));
      do_stop(w);
      cyc(HOLD - 10);
      chk(en_app == expect_en(applied, nr, blk), "R5 random hold window", en_app,
          expect_en(applied, nr, blk));
      cyc(20);
      chk(en_app == expect_en(applied, nr, '0), "R6 random applied at idle", en_app,
          expect_en(applied, nr, '0));
      cyc(SETUP + 5);
      chk(busy == 0, "R7 random busy settles", {{(N-1){1'b0}}, busy}, 0);
      applied = expect_en(applied, nr, '0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule